// File: doc/BRIEF.md
# ADC Sample-End Trigger Selector

This block governs the sampling phase of an analog-to-digital converter and decides which event closes that phase and launches a conversion. Software raises a sample-enable bit to open a sampling window. While the window is open, a 3-bit source code picks one terminating event. The event can be one of three hardware pulses (a timer compare match, a PWM period-end event, a charge-measurement event) or an edge on an external interrupt pin. It can also be an internal dwell counter, or software dropping the sample-enable bit. When the selected event arrives, the block emits a one-cycle convert-start pulse and closes the window on that same cycle.

Two source codes are reserved and never end a window with a conversion. Under any hardware source, software can still drop the sample-enable bit to abandon the window without a conversion. The external interrupt pin is asynchronous. It passes through a synchronizer, and a polarity input chooses whether its rising or falling edge counts.

Top module: `adc_trig_top`

## Requirements
- R1: After synchronous reset, `sampling_o` and `conv_start_o` are both low.
- R2: When `samp_bit_i` is high at a clock edge and was low at the previous edge while no window is open, `sampling_o` is high from that edge on. A level held high does not reopen a window.
- R3: `conv_start_o` is never high for two cycles in a row, and `sampling_o` falls on the same edge where `conv_start_o` rises.
- R4: With code 3'b000, dropping `samp_bit_i` while a window is open produces a convert-start pulse at the next edge.
- R5: With any code other than 3'b000, dropping `samp_bit_i` while a window is open closes the window with no convert-start pulse.
- R6: With code 3'b001, the external pin passes through two synchronizer flops. A transition of `int0_pin_i` to the level of `int0_pol_i` (1 = rising, 0 = falling) ends the window, and `conv_start_o` appears at the third edge after the pin changes. A transition the other way has no effect.
- R7: Code 3'b010 ends the window on `tmr_match_i`, code 3'b011 on `pwm_evt_i` and code 3'b110 on `ctm_evt_i`, each at the edge that samples the pulse. Pulses from sources that are not selected have no effect.
- R8: Codes 3'b100 and 3'b101 are reserved and never produce a convert-start pulse.
- R9: With code 3'b111, the window stays open for exactly `auto_time_i` cycles and then ends with a convert-start pulse. A value of 0 gives one cycle.
- R10: No trigger event produces a convert-start pulse while no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_bit_i | input | 1 | Software sample-enable bit; a rising edge opens a window |
| sel_i | input | 3 | Source code that ends the window |
| int0_pol_i | input | 1 | Active edge of the external pin (1 rising, 0 falling) |
| int0_pin_i | input | 1 | Asynchronous external interrupt pin |
| tmr_match_i | input | 1 | Timer compare pulse |
| pwm_evt_i | input | 1 | PWM period-end pulse |
| ctm_evt_i | input | 1 | Charge-measurement event pulse |
| auto_time_i | input | 5 | Dwell time in clock cycles for the counter source |
| conv_start_o | output | 1 | One-cycle convert-start pulse |
| sampling_o | output | 1 | High while a sampling window is open |

## Verification
The hardest case to reach is an external-pin edge that must land inside an open window after the synchronizer delay. A pin transition toward the inactive level must also be seen to do nothing. The stimulus first parks the pin at its idle level for several cycles so that no stale edge is left in the detector. It then opens a window and moves the pin, and it counts edges to the exact pulse cycle for both polarities. The counter source is swept over every dwell value, including zero, and every source code is crossed with every hardware pulse.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    typedef enum logic [2:0] {
        SRC_SWCLR = 3'b000,
        SRC_EXT   = 3'b001,
        SRC_TMR   = 3'b010,
        SRC_PWM   = 3'b011,
        SRC_RSV4  = 3'b100,
        SRC_RSV5  = 3'b101,
        SRC_CTM   = 3'b110,
        SRC_AUTO  = 3'b111
    } trig_src_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SAMPLE = 1'b1
    } samp_state_e;

    typedef struct packed {
        logic sw_end;
        logic ext_edge;
        logic tmr;
        logic pwm;
        logic ctm;
        logic auto_done;
    } trig_vec_t;

    function automatic logic src_is_reserved(trig_src_e s);
        return (s == SRC_RSV4) || (s == SRC_RSV5);
    endfunction

    // Zero dwell is promoted to one tick.
    function automatic int unsigned dwell_ticks(int unsigned raw);
        return (raw == 0) ? 1 : raw;
    endfunction

endpackage

// File: rtl/adc_trig_edge_sync.sv
module adc_trig_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic pol_i,
    output logic edge_o
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= pin_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], pin_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[TOP];
    end

    assign edge_o = (sync_q[TOP] != last_q) && (sync_q[TOP] == pol_i);

    // R6: a detected edge is consumed on the next cycle
    p_edge_once_r6: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> !edge_o || (pol_i != $past(pol_i)));

endmodule

// File: rtl/adc_trig_auto_timer.sv
module adc_trig_auto_timer
    import adc_trig_pkg::*;
#(
    parameter int TIME_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic [TIME_W-1:0] time_i,
    output logic              done_o
);
    localparam int CW = TIME_W + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic [CW-1:0] next_cnt;

    always_comb begin
        limit    = CW'(dwell_ticks(int'(time_i)));
        next_cnt = cnt_q + CW'(1);
        done_o   = run_i && (next_cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i || done_o) cnt_q <= '0;
        else                         cnt_q <= next_cnt;
    end

    // R9: counting restarts from zero after each expiry
    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> cnt_q == '0);

endmodule

// File: rtl/adc_trig_select.sv
module adc_trig_select
    import adc_trig_pkg::*;
(
    input  trig_src_e sel_i,
    input  trig_vec_t ev_i,
    output logic      fire_o
);
    always_comb begin
        unique case (sel_i)
            SRC_SWCLR: fire_o = ev_i.sw_end;
            SRC_EXT:   fire_o = ev_i.ext_edge;
            SRC_TMR:   fire_o = ev_i.tmr;
            SRC_PWM:   fire_o = ev_i.pwm;
            SRC_CTM:   fire_o = ev_i.ctm;
            SRC_AUTO:  fire_o = ev_i.auto_done;
            default:   fire_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_trig_top.sv
module adc_trig_top
    import adc_trig_pkg::*;
#(
    parameter int TIME_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_bit_i,
    input  logic [2:0]        sel_i,
    input  logic              int0_pol_i,
    input  logic              int0_pin_i,
    input  logic              tmr_match_i,
    input  logic              pwm_evt_i,
    input  logic              ctm_evt_i,
    input  logic [TIME_W-1:0] auto_time_i,
    output logic              conv_start_o,
    output logic              sampling_o
);
    trig_src_e   sel;
    samp_state_e state_q;
    logic        samp_prev_q;
    logic        conv_q;
    logic        ext_edge;
    logic        auto_done;
    logic        fire;
    logic        in_sample;
    trig_vec_t   ev;

    assign sel       = trig_src_e'(sel_i);
    assign in_sample = (state_q == ST_SAMPLE);

    adc_trig_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (int0_pin_i),
        .pol_i  (int0_pol_i),
        .edge_o (ext_edge)
    );

    adc_trig_auto_timer #(.TIME_W(TIME_W)) u_auto (
        .clk    (clk),
        .rst    (rst),
        .run_i  (in_sample),
        .time_i (auto_time_i),
        .done_o (auto_done)
    );

    always_comb begin
        ev.sw_end    = !samp_bit_i;
        ev.ext_edge  = ext_edge;
        ev.tmr       = tmr_match_i;
        ev.pwm       = pwm_evt_i;
        ev.ctm       = ctm_evt_i;
        ev.auto_done = auto_done;
    end

    adc_trig_select u_sel (
        .sel_i  (sel),
        .ev_i   (ev),
        .fire_o (fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            samp_prev_q <= 1'b0;
            conv_q      <= 1'b0;
        end else begin
            samp_prev_q <= samp_bit_i;
            conv_q      <= in_sample && fire;
            unique case (state_q)
                ST_IDLE: begin
                    if (samp_bit_i && !samp_prev_q) state_q <= ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    if (fire)                                  state_q <= ST_IDLE;
                    else if (!samp_bit_i && sel != SRC_SWCLR)  state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign conv_start_o = conv_q;
    assign sampling_o   = in_sample;

    // R3: single-cycle pulse
    p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |=> !conv_start_o);
    // R3: window closes as the pulse appears
    p_close_with_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_start_o) |-> $fell(sampling_o));
    // R2: rising enable opens a window
    p_open_r2: assert property (@(posedge clk) disable iff (rst)
        (!sampling_o && samp_bit_i && !samp_prev_q) |=> sampling_o);
    // R5: abandon without conversion
    p_abort_r5: assert property (@(posedge clk) disable iff (rst)
        (sampling_o && !samp_bit_i && sel != SRC_SWCLR && sel != SRC_AUTO
         && !(sel == SRC_EXT && ext_edge) && !(sel == SRC_TMR && tmr_match_i)
         && !(sel == SRC_PWM && pwm_evt_i) && !(sel == SRC_CTM && ctm_evt_i))
        |=> !conv_start_o && !sampling_o);
    // R8: reserved codes stay silent
    p_reserved_r8: assert property (@(posedge clk) disable iff (rst)
        (src_is_reserved(sel)) |=> !conv_start_o);
    // R10: nothing converts outside a window
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !sampling_o |=> !conv_start_o);

endmodule

// File: tb/adc_trig_top_tb.sv
module adc_trig_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       samp_bit = 1'b0;
    logic [2:0] sel = 3'b000;
    logic       pol = 1'b1;
    logic       pin = 1'b0;
    logic       tmr = 1'b0;
    logic       pwm = 1'b0;
    logic       ctm = 1'b0;
    logic [4:0] atime = 5'd31;
    logic       conv;
    logic       samp;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    adc_trig_top u_dut (
        .clk(clk), .rst(rst), .samp_bit_i(samp_bit), .sel_i(sel),
        .int0_pol_i(pol), .int0_pin_i(pin), .tmr_match_i(tmr),
        .pwm_evt_i(pwm), .ctm_evt_i(ctm), .auto_time_i(atime),
        .conv_start_o(conv), .sampling_o(samp)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic open_window(input string req);
        samp_bit = 1'b0; tick();
        samp_bit = 1'b1; tick();
        chk(samp == 1'b1, req, samp, 1);
    endtask

    task automatic close_all();
        samp_bit = 1'b0; tick(); tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        finish_run();
    end

    initial begin
        #1;
        tick(); tick();
        // R1 reset state
        chk(samp == 1'b0, "R1 sampling", samp, 0);
        chk(conv == 1'b0, "R1 conv", conv, 0);
        rst = 1'b0;
        tick();

        // R2: level held high does not reopen
        sel = 3'b010;
        open_window("R2 open");
        tmr = 1'b1; tick(); tmr = 1'b0;
        chk(conv == 1'b1 && samp == 1'b0, "R3 close with pulse", {conv, samp}, 2);
        tick();
        chk(conv == 1'b0, "R3 single pulse", conv, 0);
        repeat (3) tick();
        chk(samp == 1'b0, "R2 no reopen on held level", samp, 0);
        close_all();

        // R4 software-clear end
        sel = 3'b000;
        open_window("R2 open sw");
        samp_bit = 1'b0; tick();
        chk(conv == 1'b1 && samp == 1'b0, "R4 sw clear converts", {conv, samp}, 2);
        tick();
        chk(conv == 1'b0, "R3 single pulse sw", conv, 0);

        // R5 abort for each non-zero code
        atime = 5'd31;
        for (int c = 1; c < 8; c++) begin
            sel = 3'(c);
            open_window("R2 open abort");
            samp_bit = 1'b0; tick();
            chk(conv == 1'b0 && samp == 1'b0, "R5 abort", {conv, samp}, 0);
            tick();
        end

        // R7 / R8: every code crossed with every pulse source
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 3; s++) begin
                bit hit;
                hit = (s == 0 && c == 2) || (s == 1 && c == 3) || (s == 2 && c == 6);
                sel = 3'(c);
                open_window("R2 open sweep");
                tmr = (s == 0); pwm = (s == 1); ctm = (s == 2);
                tick();
                tmr = 1'b0; pwm = 1'b0; ctm = 1'b0;
                chk(conv == hit, (c == 4 || c == 5) ? "R8 reserved" : "R7 source select",
                    conv, hit);
                chk(samp == !hit, "R7 window state", samp, !hit);
                close_all();
            end
        end

        // R8: reserved codes held long with all events
        for (int c = 4; c < 6; c++) begin
            sel = 3'(c);
            pol = 1'b1; pin = 1'b0; repeat (4) tick();
            open_window("R2 open rsv");
            pin = 1'b1;
            for (int k = 0; k < 40; k++) begin
                tmr = 1'b1; pwm = 1'b1; ctm = 1'b1; atime = 5'd0;
                tick();
                chk(conv == 1'b0, "R8 reserved quiet", conv, 0);
            end
            tmr = 1'b0; pwm = 1'b0; ctm = 1'b0; atime = 5'd31; pin = 1'b0;
            close_all();
        end

        // R6 external edge, both polarities
        sel = 3'b001;
        for (int p = 0; p < 2; p++) begin
            pol = 1'(p); pin = !pol; repeat (4) tick();
            open_window("R2 open ext");
            pin = pol;
            tick(); chk(conv == 1'b0, "R6 edge early 1", conv, 0);
            tick(); chk(conv == 1'b0, "R6 edge early 2", conv, 0);
            tick(); chk(conv == 1'b1 && samp == 1'b0, "R6 edge converts", {conv, samp}, 2);
            tick();
            // inactive direction
            pin = pol; repeat (4) tick();
            open_window("R2 open ext inv");
            pin = !pol;
            for (int k = 0; k < 5; k++) begin
                tick();
                chk(conv == 1'b0, "R6 inactive edge ignored", conv, 0);
            end
            chk(samp == 1'b1, "R6 window still open", samp, 1);
            close_all();
        end
        pin = 1'b0;

        // R9 auto sweep over every dwell value
        sel = 3'b111;
        for (int t = 0; t < 32; t++) begin
            int len;
            int exp_len;
            atime = 5'(t);
            exp_len = (t == 0) ? 1 : t;
            open_window("R2 open auto");
            len = 0;
            while (conv == 1'b0 && len < 40) begin
                tick(); len++;
            end
            chk(len == exp_len, "R9 dwell length", len, exp_len);
            chk(samp == 1'b0, "R3 auto window closes", samp, 0);
            close_all();
        end

        // R10 events while idle
        sel = 3'b010; samp_bit = 1'b0; tick(); tick();
        tmr = 1'b1; tick(); tmr = 1'b0; tick();
        chk(conv == 1'b0, "R10 idle tmr", conv, 0);
        sel = 3'b111; atime = 5'd0;
        repeat (3) begin
            tick();
            chk(conv == 1'b0, "R10 idle auto", conv, 0);
        end

        finish_run();
    end
endmodule